// File: doc/BRIEF.md
# Digital Phase/Frequency Detector with Selectable Polarity

This block compares two slow square waves sampled on a fast system clock: a divided reference and a divided feedback taken from an oscillator. It drives the two control lines of a charge pump and an enable that tells the pump whether to drive at all. Each input passes through a short synchronizer, and the block finds the rising edge of each one. The edge that arrives first raises an error flag. That flag stays up until the edge of the other input arrives. The width of an error pulse, counted in system clock cycles, is therefore the phase difference between the two inputs.

When both edges fall in the same cycle, they cancel each other and no pulse is produced. While a flag is pending, further edges of the same input are ignored. This lets the block also correct a frequency error, and the sign of the correction stays right.

A run-time polarity input decides which flag drives which pump line. This allows for oscillators whose frequency falls as their tuning voltage rises. A drive-strength code passes through to the pump, but only while a correction is being applied. At all other times the enable is low, which means the pump output is high-impedance.

Top module: `pfd_core`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises, `up_o`, `dn_o` and `oe_o` are 0 and `cur_o` is all zeros.
- R2: A rising edge of `ref_i` that reaches the detector while no flag is pending, and without a feedback edge in the same cycle, sets the reference-leading flag. The flag reaches the outputs SYNC_STAGES+1 clock edges after the input is sampled high. A reference leading the feedback by d cycles at equal period gives pulses exactly d cycles wide.
- R3: The feedback side mirrors R2. A rising edge of `fb_i` that reaches the detector sets the feedback-leading flag, and the pulse width equals the lead in cycles.
- R4: An edge on the opposite input clears a pending flag in the cycle it arrives. Edges on both inputs in the same cycle produce no flag. The two flags are never set together, and phase-aligned inputs leave `oe_o` low permanently.
- R5: Rising edges of an input whose own flag is already pending have no effect. When the reference runs faster than the feedback and `pol_i`=1, `dn_o` never asserts.
- R6: With `pol_i`=1, `up_o` carries the reference-leading flag and `dn_o` the feedback-leading flag. With `pol_i`=0 the two are swapped. The change takes effect in the same cycle, with no register in the path.
- R7: `oe_o` is 1 exactly when `up_o` or `dn_o` is 1. A 0 on `oe_o` means the pump is high-impedance.
- R8: `cur_o` equals `cur_i` while `oe_o` is 1, and is all zeros otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Divided reference wave |
| fb_i | input | 1 | Divided feedback wave |
| pol_i | input | 1 | 1 = positive polarity, 0 = swapped |
| cur_i | input | CUR_W | Requested pump drive strength code |
| up_o | output | 1 | Pump source (raise tuning voltage) |
| dn_o | output | 1 | Pump sink (lower tuning voltage) |
| oe_o | output | 1 | Pump drive enable; 0 means high-impedance |
| cur_o | output | CUR_W | Drive strength code, gated by `oe_o` |

## Verification
The bench builds the block with SYNC_STAGES=2 and CUR_W=3. This makes the full three-register latency from an input edge to a flag visible, so that latency has to be modelled exactly. A three-bit strength code makes a wrongly gated or truncated `cur_o` show up with several distinct nonzero values. Waves with equal periods and leads of a few cycles in either direction give pulse widths that can be checked exactly. Unequal periods and coincident edges reach the cancel and ignore paths of R4 and R5.

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int SYNC_STAGES = 2,
  parameter int CUR_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_i,
  input  logic             fb_i,
  input  logic             pol_i,
  input  logic [CUR_W-1:0] cur_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             oe_o,
  output logic [CUR_W-1:0] cur_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] ref_sy, fb_sy;
  logic          ref_d, fb_d;
  logic          ref_rise, fb_rise;
  logic          lead_q, lag_q;
  logic          want_lead, want_lag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sy <= '0;
      fb_sy  <= '0;
      ref_d  <= 1'b0;
      fb_d   <= 1'b0;
    end else begin
      ref_sy[0] <= ref_i;
      fb_sy[0]  <= fb_i;
      for (int k = 1; k < SYNC_STAGES; k++) begin
        ref_sy[k] <= ref_sy[k-1];
        fb_sy[k]  <= fb_sy[k-1];
      end
      ref_d <= ref_sy[LAST];
      fb_d  <= fb_sy[LAST];
    end
  end

  assign ref_rise = ref_sy[LAST] & ~ref_d;
  assign fb_rise  = fb_sy[LAST] & ~fb_d;

  assign want_lead = lead_q | ref_rise;
  assign want_lag  = lag_q | fb_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_q <= 1'b0;
      lag_q  <= 1'b0;
    end else begin
      lead_q <= want_lead & ~want_lag;
      lag_q  <= want_lag & ~want_lead;
    end
  end

  assign up_o  = pol_i ? lead_q : lag_q;
  assign dn_o  = pol_i ? lag_q : lead_q;
  assign oe_o  = lead_q | lag_q;
  assign cur_o = oe_o ? cur_i : '0;
endmodule

// File: rtl/pfd_core_chk.sv
module pfd_core_chk #(
  parameter int CUR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pol_i,
  input logic             up_o,
  input logic             dn_o,
  input logic             oe_o,
  input logic [CUR_W-1:0] cur_o,
  input logic             lead_q,
  input logic             lag_q,
  input logic             ref_rise,
  input logic             fb_rise
);
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_q && lag_q));

  p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && fb_rise && !lead_q && !lag_q) |=> (!lead_q && !lag_q));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_q && fb_rise) |=> !lead_q);

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !fb_rise && !lag_q) |=> lead_q);

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rise && !ref_rise && !lead_q) |=> lag_q);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_q && !fb_rise) |=> lead_q);

  p_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pol_i |-> (dn_o == lead_q && up_o == lag_q));

  p_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> (cur_o == '0 && !up_o && !dn_o));
endmodule

bind pfd_core pfd_core_chk #(.CUR_W(CUR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pol_i(pol_i), .up_o(up_o), .dn_o(dn_o),
  .oe_o(oe_o), .cur_o(cur_o), .lead_q(lead_q), .lag_q(lag_q),
  .ref_rise(ref_rise), .fb_rise(fb_rise)
);

// File: tb/sim_pfd_core.sv
module sim_pfd_core;
  localparam int S = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_i = 1'b0, fb_i = 1'b0, pol_i = 1'b1;
  logic [CW-1:0] cur_i = '0;
  logic up_o, dn_o, oe_o;
  logic [CW-1:0] cur_o;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  pfd_core #(.SYNC_STAGES(S), .CUR_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .fb_i(fb_i), .pol_i(pol_i),
    .cur_i(cur_i), .up_o(up_o), .dn_o(dn_o), .oe_o(oe_o), .cur_o(cur_o)
  );

  always #10 clk = ~clk;

  // behavioural reference: input histories and two pending flags
  bit rh[$], fh[$];
  bit m_lead, m_lag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rh.delete(); fh.delete();
      for (int k = 0; k <= S; k++) begin rh.push_back(0); fh.push_back(0); end
      m_lead = 0; m_lag = 0;
    end else begin
      bit rr, fr, a, b;
      rh.push_back(ref_i); fh.push_back(fb_i);
      if (rh.size() > S + 2) begin void'(rh.pop_front()); void'(fh.pop_front()); end
      rr = rh[rh.size()-1-S] && !rh[rh.size()-2-S];
      fr = fh[fh.size()-1-S] && !fh[fh.size()-2-S];
      a = m_lead || rr;
      b = m_lag || fr;
      m_lead = a && !b;
      m_lag  = b && !a;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit eu, ed, eo;
    int ec;
    eu = pol_i ? m_lead : m_lag;
    ed = pol_i ? m_lag : m_lead;
    eo = m_lead || m_lag;
    ec = eo ? int'(cur_i) : 0;
    check(up_o == eu, tag, "up_o", up_o, eu);
    check(dn_o == ed, tag, "dn_o", dn_o, ed);
    check(oe_o == eo, "R7", "oe_o", oe_o, eo);
    check(int'(cur_o) == ec, "R8", "cur_o", cur_o, ec);
  endtask

  int up_cyc, dn_cyc, oe_cyc, run_up, run_dn, bad_up, bad_dn, pulses;

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ref_i = 0; fb_i = 0;
    @(negedge clk);
    check(!up_o && !dn_o && !oe_o && cur_o == 0, "R1", "outputs in reset",
          {up_o, dn_o, oe_o}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!up_o && !dn_o && !oe_o && cur_o == 0, "R1", "outputs after reset",
          {up_o, dn_o, oe_o}, 0);
  endtask

  task automatic waves(input int n, input int pr, input int pf,
                       input int dr, input int df, input int width);
    up_cyc = 0; dn_cyc = 0; oe_cyc = 0; run_up = 0; run_dn = 0;
    bad_up = 0; bad_dn = 0; pulses = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare();
      if (up_o) begin up_cyc++; run_up++; end
      else begin
        if (run_up > 0) begin pulses++; if (run_up != width) bad_up++; end
        run_up = 0;
      end
      if (dn_o) begin dn_cyc++; run_dn++; end
      else begin
        if (run_dn > 0) begin pulses++; if (run_dn != width) bad_dn++; end
        run_dn = 0;
      end
      if (oe_o) oe_cyc++;
      if (c % 37 == 0) cur_i = CW'(c / 37 + 1);
      ref_i = (c >= dr) && (((c - dr) % pr) < pr / 2);
      fb_i  = (c >= df) && (((c - df) % pf) < pf / 2);
    end
  endtask

  initial begin
    do_reset();

    tag = "R2"; pol_i = 1;
    waves(400, 20, 20, 0, 5, 5);
    check(bad_up == 0 && pulses > 5, "R2", "up pulse width 5", bad_up, 0);
    check(dn_cyc == 0, "R2", "no dn while ref leads", dn_cyc, 0);

    do_reset();
    tag = "R3";
    waves(400, 16, 16, 3, 0, 3);
    check(bad_dn == 0 && pulses > 5, "R3", "dn pulse width 3", bad_dn, 0);
    check(up_cyc == 0, "R3", "no up while fb leads", up_cyc, 0);

    do_reset();
    tag = "R4";
    waves(300, 12, 12, 2, 2, 0);
    check(oe_cyc == 0, "R4", "aligned inputs keep high-Z", oe_cyc, 0);

    do_reset();
    tag = "R5";
    waves(600, 10, 16, 0, 0, 0);
    check(dn_cyc == 0, "R5", "faster ref never pulls dn", dn_cyc, 0);
    check(up_cyc > 0, "R5", "faster ref pushes up", up_cyc, 1);

    do_reset();
    tag = "R6"; pol_i = 0;
    waves(400, 20, 20, 0, 4, 4);
    check(bad_dn == 0 && pulses > 5, "R6", "swapped: dn pulse width 4", bad_dn, 0);
    check(up_cyc == 0, "R6", "swapped: no up", up_cyc, 0);

    do_reset();
    tag = "R6"; pol_i = 1;
    waves(200, 14, 18, 1, 0, 0);
    pol_i = 0;
    waves(200, 14, 18, 1, 0, 0);
    check(up_cyc + dn_cyc == oe_cyc, "R7", "enable matches activity",
          oe_cyc, up_cyc + dn_cyc);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule